// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM from a three-wire serial link (a bit clock, a word clock that marks the channel, and one data line) and delivers parallel samples. Every output is 24 bits wide and comes with a one-cycle valid strobe for its channel. All three link wires are sampled by a faster system clock through a synchronizer, so the block lives entirely in the system clock domain.

A 3-bit format code chooses the framing: right-aligned words of 16, 20 or 24 bits, left-aligned words, or the one-bit-delayed framing of I2S. The code is taken only while the power-down input is high. The receiver measures the length of every half frame against a per-format minimum. A half frame that is too short produces no sample and raises a sticky error flag.

Each half frame is handed out on the bit-clock edge where the word clock changes level, which is the edge that closes that half. So all formats share one output point, and the same edge also carries the length check.

Top module: `ser_audio_rx`

## Requirements
- R1: Format codes are fixed as follows. 0: 16-bit right-aligned. 1: 20-bit right-aligned. 4: 24-bit right-aligned. 2 and 5: 24-bit left-aligned. 3 and 6: I2S (24-bit). 7 is reserved: with code 7 the receiver gives no strobes and never raises the error flag.
- R2: Data and word clock are sampled on each rising bit-clock edge. Words arrive MSB first in two's complement.
- R3: In the right-aligned formats the word is the last N bits before the word-clock change (N = 16, 20 or 24), sign-extended to 24 bits.
- R4: In the left-aligned formats the MSB is the bit on the first rising edge that sees the new word-clock level. Bits after the 24th are dropped. If a half frame has fewer than 24 bits, the word is left-aligned and the unfilled low bits are zero.
- R5: In I2S the MSB comes one edge after the word-clock change. The final bit of a word may fall on the first edge of the next half frame. A 16-clock half frame therefore yields its 16 bits left-aligned in 24.
- R6: Word clock high is the left channel, except in the I2S formats (3, 6), where word clock low is the left channel.
- R7: Minimum rising edges per half frame: 16 for code 0, 20 for code 1, 24 for all other codes. Code 3 also accepts a half frame of exactly 16 edges.
- R8: A half frame below its minimum produces no strobe and sets the error flag. The flag stays set until power-down. Later half frames of legal length are still delivered.
- R9: The format code is latched only while power-down is high, and changes at any other time have no effect. Power-down clears the error flag and the frame alignment. The first word-clock change after power-down only aligns the receiver and produces no sample.
- R10: A strobe lasts one system clock cycle and never occurs on both channels at once. It appears on the third rising system-clock edge after the bit-clock rise that carries the word-clock change. Data outputs hold their value between strobes.
- R11: After reset the strobes, both data outputs and the error flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerDown | input | 1 | High: receiver idle, format code latched, error cleared |
| fmtCode | input | 3 | Framing selection, taken only during power-down |
| bitClk | input | 1 | Serial bit clock (asynchronous) |
| wordClk | input | 1 | Serial word/channel clock (asynchronous) |
| serData | input | 1 | Serial data line (asynchronous) |
| leftData | output | 24 | Last left-channel sample |
| leftValid | output | 1 | One-cycle strobe for a new left sample |
| rightData | output | 24 | Last right-channel sample |
| rightValid | output | 1 | One-cycle strobe for a new right sample |
| frameError | output | 1 | Sticky flag for a short half frame |

## Verification
A strobe and any error update are due on the third rising system-clock edge after the bit-clock rise that closes the half frame. The bench drives the link wires on falling system-clock edges and holds each bit-clock level for four cycles. A monitor on falling edges compares the time of every strobe with the time the bench drove the rising bit clock, and requires a gap of exactly three periods. Words and error flags are compared once a short trailing half frame has closed the stream, well after the last result is due.

// File: rtl/ser_audio_rx_pkg.sv
package ser_audio_rx_pkg;

  localparam int SAMPLE_W = 24;
  localparam int IDX_W    = 5;

  typedef enum logic [1:0] {
    WIDTH16 = 2'd0,
    WIDTH20 = 2'd1,
    WIDTH24 = 2'd2
  } lsbWidth_e;

  // strobes from the control to the datapath, all for the current system cycle
  typedef struct packed {
    logic                 tick;       // rising bit-clock edge while running
    logic                 boundary;   // word clock changed on this tick
    logic                 clear;      // power-down
    logic                 emitLeft;
    logic                 emitRight;
    logic                 lsbMode;    // right-aligned framing
    lsbWidth_e            lsbWidth;
    logic                 capWrite;   // place current bit into the left-aligned capture
    logic [IDX_W-1:0]     capIdx;     // bit index counted from the MSB
    logic                 tailWrite;  // I2S: current bit is the last bit of the ending word
    logic [IDX_W-1:0]     tailIdx;
  } rxCtl_t;

endpackage

// File: rtl/ser_audio_rx_sync.sv
module ser_audio_rx_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2   // at least 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] asyncIn,
  output logic [LINES-1:0] syncOut
);

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], asyncIn[g]};
    end
    assign syncOut[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/ser_audio_rx_ctrl.sv
module ser_audio_rx_ctrl
  import ser_audio_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerDown,
  input  logic [2:0] fmtCode,
  input  logic       bclkS,
  input  logic       lrS,
  output rxCtl_t     ctl,
  output logic [2:0] activeFmt,
  output logic       errFlag
);

  localparam logic [CNT_W-1:0] LEN16 = CNT_W'(16);
  localparam logic [CNT_W-1:0] LEN20 = CNT_W'(20);
  localparam logic [CNT_W-1:0] SPAN  = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [2:0]       fmtReg;
  logic             bclkLast, lrPrev, primed, synced;
  logic [CNT_W-1:0] cnt;

  logic             rise, tick, boundary, lenOk, isLsb, isI2s, isReserved, endedLeft, emit;
  logic [CNT_W-1:0] minLen, pos, offset, rel, tailPos;

  assign rise      = bclkS & ~bclkLast;
  assign tick      = rise & ~powerDown;
  assign boundary  = tick & primed & (lrS != lrPrev);
  assign activeFmt = fmtReg;

  always_comb begin
    isLsb      = (fmtReg == 3'd0) || (fmtReg == 3'd1) || (fmtReg == 3'd4);
    isI2s      = (fmtReg == 3'd3) || (fmtReg == 3'd6);
    isReserved = (fmtReg == 3'd7);
    case (fmtReg)
      3'd0:    minLen = LEN16;
      3'd1:    minLen = LEN20;
      default: minLen = SPAN;
    endcase
    lenOk     = (cnt >= minLen) || ((fmtReg == 3'd3) && (cnt == LEN16));
    endedLeft = isI2s ? ~lrPrev : lrPrev;
    emit      = boundary & synced & lenOk & ~isReserved;
    pos       = boundary ? '0 : cnt;
    offset    = isI2s ? ONE : '0;
    rel       = pos - offset;
    tailPos   = cnt - ONE;

    ctl           = '0;
    ctl.tick      = tick;
    ctl.boundary  = boundary;
    ctl.clear     = powerDown;
    ctl.emitLeft  = emit & endedLeft;
    ctl.emitRight = emit & ~endedLeft;
    ctl.lsbMode   = isLsb;
    case (fmtReg)
      3'd0:    ctl.lsbWidth = WIDTH16;
      3'd1:    ctl.lsbWidth = WIDTH20;
      default: ctl.lsbWidth = WIDTH24;
    endcase
    ctl.capWrite  = tick & ~isLsb & ~isReserved & (pos >= offset) & (rel < SPAN);
    ctl.capIdx    = rel[IDX_W-1:0];
    ctl.tailWrite = boundary & isI2s & (cnt != '0) & (tailPos < SPAN);
    ctl.tailIdx   = tailPos[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bclkLast <= 1'b0;
    else       bclkLast <= bclkS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtReg  <= '0;
      lrPrev  <= 1'b0;
      primed  <= 1'b0;
      synced  <= 1'b0;
      cnt     <= '0;
      errFlag <= 1'b0;
    end else if (powerDown) begin
      fmtReg  <= fmtCode;
      lrPrev  <= 1'b0;
      primed  <= 1'b0;
      synced  <= 1'b0;
      cnt     <= '0;
      errFlag <= 1'b0;
    end else if (tick) begin
      lrPrev <= lrS;
      primed <= 1'b1;
      if (boundary) begin
        synced <= 1'b1;
        cnt    <= ONE;
        if (synced && !lenOk && !isReserved) errFlag <= 1'b1;
      end else if (cnt != '1) begin
        cnt <= cnt + ONE;
      end
    end
  end

  AST_FMT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !powerDown |=> $stable(fmtReg)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !powerDown |=> errFlag); // R8
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> !errFlag); // R9

endmodule

// File: rtl/ser_audio_rx_dp.sv
module ser_audio_rx_dp
  import ser_audio_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  rxCtl_t              ctl,
  input  logic                sdS,
  output logic [SAMPLE_W-1:0] leftData,
  output logic                leftValid,
  output logic [SAMPLE_W-1:0] rightData,
  output logic                rightValid
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] rollReg, capReg, capNext, lsbWord, msbWord, word;

  always_comb begin
    case (ctl.lsbWidth)
      WIDTH16: lsbWord = {{(SAMPLE_W-16){rollReg[15]}}, rollReg[15:0]};
      WIDTH20: lsbWord = {{(SAMPLE_W-20){rollReg[19]}}, rollReg[19:0]};
      default: lsbWord = rollReg;
    endcase
    msbWord = capReg;
    if (ctl.tailWrite) msbWord[TOP_IDX - ctl.tailIdx] = sdS;
    word = ctl.lsbMode ? lsbWord : msbWord;

    capNext = ctl.boundary ? '0 : capReg;
    if (ctl.capWrite) capNext[TOP_IDX - ctl.capIdx] = sdS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rollReg    <= '0;
      capReg     <= '0;
      leftData   <= '0;
      rightData  <= '0;
      leftValid  <= 1'b0;
      rightValid <= 1'b0;
    end else begin
      leftValid  <= 1'b0;
      rightValid <= 1'b0;
      if (ctl.clear) begin
        rollReg <= '0;
        capReg  <= '0;
      end else if (ctl.tick) begin
        rollReg <= {rollReg[SAMPLE_W-2:0], sdS};
        capReg  <= capNext;
        if (ctl.emitLeft) begin
          leftData  <= word;
          leftValid <= 1'b1;
        end
        if (ctl.emitRight) begin
          rightData  <= word;
          rightValid <= 1'b1;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (leftValid || rightValid) |=> !(leftValid || rightValid)); // R10
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rstN)
    !(leftValid && rightValid)); // R10
  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> !leftValid && !rightValid); // R9
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !leftValid |-> $stable(leftData)); // R10

endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx
  import ser_audio_rx_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                powerDown,
  input  logic [2:0]          fmtCode,
  input  logic                bitClk,
  input  logic                wordClk,
  input  logic                serData,
  output logic [SAMPLE_W-1:0] leftData,
  output logic                leftValid,
  output logic [SAMPLE_W-1:0] rightData,
  output logic                rightValid,
  output logic                frameError
);

  logic [2:0] pinSync;
  logic [2:0] activeFmt;
  rxCtl_t     ctl;

  ser_audio_rx_sync #(.LINES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({serData, wordClk, bitClk}),
    .syncOut (pinSync)
  );

  ser_audio_rx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .powerDown (powerDown),
    .fmtCode   (fmtCode),
    .bclkS     (pinSync[0]),
    .lrS       (pinSync[1]),
    .ctl       (ctl),
    .activeFmt (activeFmt),
    .errFlag   (frameError)
  );

  ser_audio_rx_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .sdS        (pinSync[2]),
    .leftData   (leftData),
    .leftValid  (leftValid),
    .rightData  (rightData),
    .rightValid (rightValid)
  );

  AST_SEXT16: assert property (@(posedge clk) disable iff (!rstN)
    leftValid && (activeFmt == 3'd0) |->
      (leftData[SAMPLE_W-1:15] == '0) || (leftData[SAMPLE_W-1:15] == '1)); // R3

endmodule

// File: tb/ser_audio_rx_bench.sv
module ser_audio_rx_bench;

  localparam int HALF = 10;   // 50 MHz system clock

  logic        clk = 1'b0;
  logic        rstN, powerDown, bitClk, wordClk, serData;
  logic [2:0]  fmtCode;
  logic [23:0] leftData, rightData;
  logic        leftValid, rightValid, frameError;

  always #HALF clk = ~clk;

  ser_audio_rx u_ser_audio_rx (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .fmtCode(fmtCode),
    .bitClk(bitClk), .wordClk(wordClk), .serData(serData),
    .leftData(leftData), .leftValid(leftValid),
    .rightData(rightData), .rightValid(rightValid), .frameError(frameError)
  );

  int          nCheck = 0;
  int          nFail  = 0;
  time         riseTime = 0;
  logic [23:0] gotVal [16];
  logic        gotLeft [16];
  int          gotCount = 0;
  logic [23:0] vals [8];
  int          lens [8];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nCheck++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nCheck - nFail, nCheck);
    $finish;
  endtask

  // strobe monitor: latency R10, record words
  always @(negedge clk) begin
    if (leftValid || rightValid) begin
      check(($time - riseTime) == 6 * HALF, "R10", "strobe latency",
            32'($time - riseTime), 32'(6 * HALF));
      if (gotCount < 16) begin
        gotVal[gotCount]  = leftValid ? leftData : rightData;
        gotLeft[gotCount] = leftValid;
        gotCount++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nCheck++;
    nFail++;
    $display("FAIL R10 watchdog: actual hung expected done");
    finishRun();
  end

  function automatic bit isLsbF(int f);  return (f == 0) || (f == 1) || (f == 4); endfunction
  function automatic bit isI2sF(int f);  return (f == 3) || (f == 6); endfunction
  function automatic int widthF(int f);  return (f == 0) ? 16 : (f == 1) ? 20 : 24; endfunction
  function automatic bit okF(int f, int h);
    if (f == 7) return 1'b0;
    return (h >= widthF(f)) || ((f == 3) && (h == 16));
  endfunction

  function automatic logic encBit(int f, int h, int j);
    int w, k, hp;
    if (f == 7) return 1'b0;
    if (isLsbF(f)) begin
      w = widthF(f);
      if (j < lens[h] - w) return 1'b0;
      k = w - 1 - (j - (lens[h] - w));
      return vals[h][k];
    end
    if (isI2sF(f)) begin
      if (j == 0) begin
        if (h == 0) return 1'b0;
        hp = lens[h-1] - 1;
        return (hp < 24) ? vals[h-1][23-hp] : 1'b0;
      end
      k = j - 1;
    end else begin
      k = j;
    end
    return (k < 24) ? vals[h][23-k] : 1'b0;
  endfunction

  function automatic logic [23:0] expWord(int f, int h);
    logic [23:0] m;
    int n;
    if (isLsbF(f)) begin
      n = widthF(f);
      m = 24'((1 << n) - 1);
      return vals[h][n-1] ? (vals[h] | ~m) : (vals[h] & m);
    end
    n = (lens[h] < 24) ? lens[h] : 24;
    m = ~24'((1 << (24 - n)) - 1);
    return vals[h] & m;
  endfunction

  task automatic driveBit(input logic lr, input logic d);
    @(negedge clk);
    bitClk = 1'b0; wordClk = lr; serData = d;
    repeat (3) @(negedge clk);
    @(negedge clk);
    bitClk = 1'b1;
    riseTime = $time;
    repeat (3) @(negedge clk);
  endtask

  // power-down, latch f, send nh halves with lens[]/vals[], compare
  task automatic runStream(input int f, input int nh, input int laterFmt);
    logic lvlL, lv;
    int   expCount;
    bit   expErr;
    string reqV;
    @(negedge clk);
    powerDown = 1'b1; fmtCode = 3'(f); bitClk = 1'b0;
    repeat (4) @(negedge clk);
    powerDown = 1'b0;
    repeat (2) @(negedge clk);
    check(frameError == 1'b0, "R9", "error after power-down", 32'(frameError), 0);
    if (laterFmt >= 0) fmtCode = 3'(laterFmt);
    gotCount = 0;
    lvlL = isI2sF(f) ? 1'b0 : 1'b1;
    lens[nh] = 3;
    vals[nh] = '0;
    for (int j = 0; j < 3; j++) driveBit(~lvlL, 1'b0);
    for (int h = 0; h <= nh; h++) begin
      lv = (h % 2 == 0) ? lvlL : ~lvlL;
      for (int j = 0; j < lens[h]; j++) driveBit(lv, encBit(f, h, j));
    end
    repeat (6) @(negedge clk);
    reqV = isLsbF(f) ? "R2 R3" : isI2sF(f) ? "R2 R5" : "R2 R4";
    expCount = 0;
    expErr = 1'b0;
    for (int h = 0; h < nh; h++) begin
      if (okF(f, lens[h])) begin
        if (expCount < gotCount) begin
          check(gotVal[expCount] == expWord(f, h), reqV, "sample word",
                32'(gotVal[expCount]), 32'(expWord(f, h)));
          check(gotLeft[expCount] == (h % 2 == 0), "R6", "channel",
                32'(gotLeft[expCount]), 32'(h % 2 == 0));
        end
        expCount++;
      end else if (f != 7) begin
        expErr = 1'b1;
      end
    end
    check(gotCount == expCount, (f == 7) ? "R1" : "R7 R9", "strobe count",
          32'(gotCount), 32'(expCount));
    check(frameError == expErr, "R8", "error flag", 32'(frameError), 32'(expErr));
  endtask

  task automatic setVals(input int f, input int nh, input int seed);
    for (int h = 0; h < nh; h++)
      vals[h] = 24'(h * 370625 + f * 111347 + lens[h] * 1811 + 8459077 + seed * 7919);
  endtask

  initial begin
    int hs [4];
    hs = '{16, 20, 24, 32};
    rstN = 1'b0; powerDown = 1'b1; fmtCode = 3'd0;
    bitClk = 1'b0; wordClk = 1'b0; serData = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!leftValid && !rightValid, "R11", "strobes after reset",
          32'({leftValid, rightValid}), 0);
    check(leftData == '0 && rightData == '0, "R11", "data after reset",
          32'(leftData | rightData), 0);
    check(frameError == 1'b0, "R11", "error after reset", 32'(frameError), 0);

    // sweep every code against every half-frame length (R1, R3..R8)
    for (int f = 0; f < 8; f++) begin
      for (int i = 0; i < 4; i++) begin
        for (int h = 0; h < 4; h++) lens[h] = hs[i];
        setVals(f, 4, i);
        runStream(f, 4, -1);
      end
    end

    // one short half among legal ones: sticky error, others delivered (R8)
    lens[0] = 20; lens[1] = 32; lens[2] = 32; lens[3] = 32;
    setVals(5, 4, 11);
    runStream(5, 4, -1);
    lens[0] = 16; lens[1] = 16; lens[2] = 20; lens[3] = 16;
    setVals(3, 4, 12);
    runStream(3, 4, -1);

    // 64 edges per half frame
    for (int h = 0; h < 4; h++) lens[h] = 64;
    setVals(4, 4, 13);
    runStream(4, 4, -1);
    setVals(6, 4, 14);
    runStream(6, 4, -1);

    // format changes while running are ignored (R9)
    for (int h = 0; h < 4; h++) lens[h] = 32;
    setVals(0, 4, 15);
    runStream(0, 4, 5);
    setVals(5, 4, 16);
    runStream(5, 4, 0);

    finishRun();
  end

endmodule